// File: doc/BRIEF.md
# GPIO Port with Per-Line Interrupt Detection

This block is one general-purpose I/O port of `LINES` pins, eight by default. It holds an output value register and a direction register, and it reads the pins back through a synchroniser. Every line also has an interrupt detector. Two separate bit-planes configure the detector. One plane picks level or edge sensing. The other picks the active sense: high or rising, or low or falling. A per-line enable mask gates each request.

Software writes the configuration registers over a simple byte-wide bus. The write is synchronous and the read is combinational. Edge events stay latched until software writes a one to the matching bit of the acknowledge register. Level requests follow the pin for as long as it sits at the active level. The safe way to reconfigure a line is to disable it, change its two mode bits, and then enable it again. This sequence never leaves a stale event behind.

All active requests are ORed into a single port interrupt. When the `PER_LINE_IRQ` parameter is set, each line also drives its own interrupt output.

Top module: `gpio_irq_port`

## Requirements
- R1: The output value register sits at address 0, and a write there appears on `gpio_out` after the next clock edge. A read of address 0 returns the stored output value for lines whose direction bit is 1. For lines whose direction bit is 0, it returns the synchronised pin value.
- R2: The direction register sits at address 1. A bit of 1 makes that line an output, which drives `gpio_oe` high. A bit of 0 makes it an input.
- R3: After reset, every register reads 0, `gpio_out` and `gpio_oe` are 0, and no interrupt output is active.
- R4: The enable register sits at address 4. Only enabled lines can request an interrupt. Once enable bits are written to 0, the interrupt outputs of those lines are low from the next cycle on, and any edge event latched for them is discarded.
- R5: The mode register sits at address 2, and the polarity register at address 3. A mode bit of 0 selects level sensing. A polarity bit of 1 means active-high and 0 means active-low. A level request is present exactly while the synchronised pin matches the polarity. Writing an acknowledge has no effect on it.
- R6: A mode bit of 1 selects edge sensing. A polarity bit of 1 means rising and 0 means falling. A detected edge latches a request that stays present after the pin returns.
- R7: The acknowledge register sits at address 6. Writing a 1 to a bit clears the latched edge event of that line. Bits written as 0 leave their lines untouched, and reads of address 6 return 0. An edge detected in the same cycle as the acknowledge keeps the event.
- R8: An edge that arrives while its line is disabled is not latched. As a result, changing mode or polarity while the line is disabled leaves no request pending once it is enabled again.
- R9: The status register sits at address 5. It reads back the lines that are currently requesting an interrupt.
- R10: `irq_combined` is the OR of all line requests. With `PER_LINE_IRQ` = 1, `irq_lines` carries each line's request. With `PER_LINE_IRQ` = 0, `irq_lines` is held at 0.
- R11: Pin inputs pass through a two-flop synchroniser. A pin change is not visible in read data after one clock edge, and it is visible after two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register select |
| bus_we | input | 1 | Write strobe, sampled at the clock edge |
| bus_wdata | input | LINES | Write data |
| bus_rdata | output | LINES | Combinational read data for `bus_addr` |
| pin_in | input | LINES | Asynchronous pin levels |
| gpio_out | output | LINES | Output values toward the pads |
| gpio_oe | output | LINES | Output enables (direction) |
| irq_combined | output | 1 | OR of all line requests |
| irq_lines | output | LINES | Per-line requests, or 0 when the variant is off |

## Verification
Level sensing is tried with the pins all low and then all high, using mixed polarities. This shows that the request follows the pin and the polarity bit rather than a latch, and that an acknowledge cannot clear it. Edge sensing is tried in three phases. First, falling edges arrive while the lines are disabled. Then rising edges arrive on the active-high half, followed by falling edges on the active-low half. These phases separate discarded events, polarity-correct latching and persistence. Partial and empty acknowledges then show that clearing is per bit. A pin change sampled one edge and two edges later pins down the synchroniser depth. A second instance with `PER_LINE_IRQ` = 0 shows the variant difference.

// File: rtl/gpio_irq_pkg.sv
`timescale 1ns/1ps
package gpio_irq_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        SEL_DOUT = 3'd0,
        SEL_DIR  = 3'd1,
        SEL_MODE = 3'd2,
        SEL_POL  = 3'd3,
        SEL_EN   = 3'd4,
        SEL_STAT = 3'd5,
        SEL_ACK  = 3'd6,
        SEL_NONE = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic prev;
        logic hit;
    } det_state_t;
endpackage

// File: rtl/gpio_pin_sync.sv
`timescale 1ns/1ps
module gpio_pin_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_in;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_line_detect.sv
`timescale 1ns/1ps
module gpio_line_detect
    import gpio_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pin_s,
    input  logic en,
    input  logic edge_mode,
    input  logic active_high,
    input  logic ack,
    output logic req
);
    det_state_t st_d, st_q;
    logic       evt;

    always_comb begin
        evt = active_high ? (pin_s & ~st_q.prev) : (~pin_s & st_q.prev);
        st_d.prev = pin_s;
        if (!en || !edge_mode) st_d.hit = 1'b0;
        else if (evt)          st_d.hit = 1'b1;
        else if (ack)          st_d.hit = 1'b0;
        else                   st_d.hit = st_q.hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req = en & (edge_mode ? st_q.hit : ~(pin_s ^ active_high));
endmodule

// File: rtl/gpio_irq_port.sv
`timescale 1ns/1ps
module gpio_irq_port
    import gpio_irq_pkg::*;
#(
    parameter int LINES        = 8,
    parameter int SYNC_STAGES  = 2,
    parameter bit PER_LINE_IRQ = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [LINES-1:0]  bus_wdata,
    output logic [LINES-1:0]  bus_rdata,
    input  logic [LINES-1:0]  pin_in,
    output logic [LINES-1:0]  gpio_out,
    output logic [LINES-1:0]  gpio_oe,
    output logic              irq_combined,
    output logic [LINES-1:0]  irq_lines
);
    typedef struct packed {
        logic [LINES-1:0] dout;
        logic [LINES-1:0] dir;
        logic [LINES-1:0] mode;
        logic [LINES-1:0] pol;
        logic [LINES-1:0] en;
    } cfg_t;

    cfg_t             cfg_d, cfg_q;
    logic [LINES-1:0] pins_s;
    logic [LINES-1:0] ack_vec;
    logic [LINES-1:0] req_vec;
    reg_sel_e         sel;

    assign sel = reg_sel_e'(bus_addr);

    gpio_pin_sync #(.W(LINES), .STAGES(SYNC_STAGES)) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pins_s)
    );

    always_comb begin
        cfg_d   = cfg_q;
        ack_vec = '0;
        if (bus_we) begin
            case (sel)
                SEL_DOUT: cfg_d.dout = bus_wdata;
                SEL_DIR:  cfg_d.dir  = bus_wdata;
                SEL_MODE: cfg_d.mode = bus_wdata;
                SEL_POL:  cfg_d.pol  = bus_wdata;
                SEL_EN:   cfg_d.en   = bus_wdata;
                SEL_ACK:  ack_vec    = bus_wdata;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    for (genvar g = 0; g < LINES; g++) begin : g_line
        gpio_line_detect det_i (
            .clk         (clk),
            .rst_n       (rst_n),
            .pin_s       (pins_s[g]),
            .en          (cfg_q.en[g]),
            .edge_mode   (cfg_q.mode[g]),
            .active_high (cfg_q.pol[g]),
            .ack         (ack_vec[g]),
            .req         (req_vec[g])
        );
    end

    always_comb begin
        case (sel)
            SEL_DOUT: bus_rdata = (cfg_q.dir & cfg_q.dout) | (~cfg_q.dir & pins_s);
            SEL_DIR:  bus_rdata = cfg_q.dir;
            SEL_MODE: bus_rdata = cfg_q.mode;
            SEL_POL:  bus_rdata = cfg_q.pol;
            SEL_EN:   bus_rdata = cfg_q.en;
            SEL_STAT: bus_rdata = req_vec;
            default:  bus_rdata = '0;
        endcase
    end

    assign gpio_out     = cfg_q.dout;
    assign gpio_oe      = cfg_q.dir;
    assign irq_combined = |req_vec;

    if (PER_LINE_IRQ) begin : g_split
        assign irq_lines = req_vec;
    end else begin : g_merged
        assign irq_lines = '0;
    end
endmodule

// File: rtl/gpio_irq_port_chk.sv
`timescale 1ns/1ps
module gpio_irq_port_chk
    import gpio_irq_pkg::*;
#(
    parameter int LINES        = 8,
    parameter bit PER_LINE_IRQ = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [LINES-1:0]  bus_wdata,
    input logic [LINES-1:0]  gpio_out,
    input logic [LINES-1:0]  gpio_oe,
    input logic              irq_combined,
    input logic [LINES-1:0]  irq_lines
);
    // R1
    a_r1_dout_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == SEL_DOUT) |=> gpio_out == $past(bus_wdata));

    // R2
    a_r2_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == SEL_DIR) |=> gpio_oe == $past(bus_wdata));

    // R4
    a_r4_disable_quiets: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == SEL_EN && bus_wdata == '0) |=> !irq_combined);

    // R10
    if (PER_LINE_IRQ) begin : g_split
        a_r10_lines_match: assert property (@(posedge clk) disable iff (!rst_n)
            irq_combined == (|irq_lines));
    end else begin : g_merged
        a_r10_lines_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            irq_lines == '0);
    end
endmodule

bind gpio_irq_port gpio_irq_port_chk #(.LINES(LINES), .PER_LINE_IRQ(PER_LINE_IRQ)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_addr     (bus_addr),
    .bus_we       (bus_we),
    .bus_wdata    (bus_wdata),
    .gpio_out     (gpio_out),
    .gpio_oe      (gpio_oe),
    .irq_combined (irq_combined),
    .irq_lines    (irq_lines)
);

// File: tb/gpio_irq_port_tb_top.sv
`timescale 1ns/1ps
module gpio_irq_port_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] addr = '0;
    logic       we = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] pins = '0;
    logic [7:0] rdata, dout, oe, lines;
    logic       irq;
    logic [7:0] rdata_m, dout_m, oe_m, lines_m;
    logic       irq_m;
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    gpio_irq_port #(.LINES(8), .SYNC_STAGES(2), .PER_LINE_IRQ(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
        .bus_rdata(rdata), .pin_in(pins), .gpio_out(dout), .gpio_oe(oe),
        .irq_combined(irq), .irq_lines(lines)
    );

    gpio_irq_port #(.LINES(8), .SYNC_STAGES(2), .PER_LINE_IRQ(1'b0)) dut_m_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
        .bus_rdata(rdata_m), .pin_in(pins), .gpio_out(dout_m), .gpio_oe(oe_m),
        .irq_combined(irq_m), .irq_lines(lines_m)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic set_pins(input logic [7:0] v);
        @(negedge clk);
        pins = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check("R3 gpio_oe", oe, 8'h00);
        check("R3 gpio_out", dout, 8'h00);
        check("R3 irq_combined", {7'd0, irq}, 8'h00);
        for (int a = 1; a < 8; a++) begin
            rd(a[2:0], d);
            check("R3 register reset", d, 8'h00);
        end
    endtask

    task automatic t_data_dir();
        logic [7:0] d;
        wr(3'd1, 8'hF0);
        check("R2 gpio_oe", oe, 8'hF0);
        wr(3'd0, 8'hA5);
        check("R1 gpio_out", dout, 8'hA5);
        set_pins(8'h3C);
        rd(3'd0, d);
        check("R1 mixed readback", d, 8'hAC);
    endtask

    task automatic t_sync();
        @(negedge clk);
        addr = 3'd0;
        pins = 8'h03;
        @(negedge clk);
        #1 check("R11 one edge old", rdata, 8'hAC);
        @(negedge clk);
        #1 check("R11 two edges new", rdata, 8'hA3);
        wr(3'd1, 8'h00);
    endtask

    task automatic t_level();
        logic [7:0] d;
        wr(3'd3, 8'h0F);
        wr(3'd4, 8'hFF);
        set_pins(8'h00);
        rd(3'd5, d);
        check("R5 R9 level active low", d, 8'hF0);
        check("R10 per-line", lines, 8'hF0);
        check("R10 combined", {7'd0, irq}, 8'h01);
        wr(3'd6, 8'hFF);
        rd(3'd5, d);
        check("R5 ack ignored on level", d, 8'hF0);
        set_pins(8'hFF);
        rd(3'd5, d);
        check("R5 level active high", d, 8'h0F);
    endtask

    task automatic t_edge();
        logic [7:0] d;
        wr(3'd4, 8'h00);
        wr(3'd2, 8'hFF);
        wr(3'd3, 8'h0F);
        set_pins(8'h00);
        wr(3'd4, 8'hFF);
        rd(3'd5, d);
        check("R8 no pending after disabled edges", d, 8'h00);
        set_pins(8'hFF);
        rd(3'd5, d);
        check("R6 rising latched", d, 8'h0F);
        set_pins(8'h00);
        rd(3'd5, d);
        check("R6 falling latched and persistence", d, 8'hFF);
        check("R10 merged lines zero", lines_m, 8'h00);
        check("R10 merged combined", {7'd0, irq_m}, 8'h01);
        wr(3'd6, 8'h05);
        rd(3'd5, d);
        check("R7 partial ack", d, 8'hFA);
        wr(3'd6, 8'h00);
        rd(3'd5, d);
        check("R7 zero ack no effect", d, 8'hFA);
        rd(3'd6, d);
        check("R7 ack reads zero", d, 8'h00);
        @(negedge clk);
        addr = 3'd4; wdata = 8'h00; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
        #1 check("R4 irq low after disable", {7'd0, irq}, 8'h00);
        wr(3'd4, 8'hFF);
        rd(3'd5, d);
        check("R4 pending discarded", d, 8'h00);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_data_dir();
        t_sync();
        t_level();
        t_edge();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule